// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns one asynchronous NRZ serial line into a stream of characters. The line is oversampled at eight times the bit rate. The oversampling rate comes from a 16-bit divisor, which gives about 64K selectable rates. Each bit is decided by a majority vote of three samples taken at mid-bit.

Each frame can carry 1 to 8 data bits, an optional parity bit and one or two stop bits. A finished character moves from the shift register into a one-entry output buffer, so one character can be assembled while the previous one waits. The buffer is presented as a valid/ready stream. The receiver does not stall the line. If the consumer holds `m_ready` low and a new character completes, that character replaces the buffered one and the overrun flag is raised. Back-pressure is therefore advisory only: `m_data` and `m_addr` stay stable until the handshake or until the next character arrives.

Four sticky error flags cover parity, overrun, framing and break, and a fifth pin is their OR. Two multiprocessor modes mark block boundaries on a shared line. In the first, an idle line marks the next frame as an address. In the second, an extra bit in each frame marks it as an address, and data frames pass only after the receiver's own address has been seen.

Top module: `async_rx`

## Requirements
- R1: A frame is a low start bit, then `data_len`+1 data bits sent LSB first, then an address bit (`mp_mode`=10 only), then a parity bit (when enabled), then one stop bit, or two when `two_stop`=1. `m_data` carries the data bits with the unused upper bits zero.
- R2: One bit lasts (`divisor`+1)×8 clock cycles. Each bit is the majority of three samples around mid-bit. A falling edge starts a frame only if the start bit still votes low at its midpoint, so a low pulse shorter than a few samples is ignored and produces no output and no error.
- R3: `m_valid` rises when a character is buffered and falls after a cycle with `m_valid` and `m_ready` both high. While `m_ready` is low and no new character arrives, `m_valid`, `m_data` and `m_addr` hold.
- R4: If a character completes while `m_valid`=1 and `m_ready`=0, `err_overrun` sets and the buffer takes the new character.
- R5: `par_mode` selects parity: 00 = none, 01 = odd, 10 = even, 11 = none. Parity covers the data bits and the address bit. A mismatch sets `err_parity`, and the character is still delivered.
- R6: A low first stop bit sets `err_frame`. If the line then votes low for 10 further bit times, `err_break` sets, and the receiver waits for the line to go high before it looks for a new start bit.
- R7: All error flags are sticky. `err_any` is high exactly when at least one of the four flags is high.
- R8: When `mp_mode`=10, a frame whose address bit is 1 is an address. It is always delivered with `m_addr`=1. If its data equals `own_addr`, later data frames are delivered; any other address blocks them. Data frames that arrive while blocked are dropped without any output.
- R9: When `mp_mode`=01, the first frame after the line has been idle-high for at least 10 bit times is delivered with `m_addr`=1, and other frames with `m_addr`=0. When `mp_mode`=00, `m_addr` is always 0.
- R10: `soft_rst` clears all error flags, the buffer-valid flag and the address selection, and returns the receiver to hunting for a start bit.
- R11: After `rst_n` the receiver has `m_valid`=0 and all error flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of flags, buffer and frame state |
| rxd | input | 1 | Serial line, idle high |
| divisor | input | 16 | Oversample divider; bit = (divisor+1)×8 clocks |
| data_len | input | 3 | Data bits per frame minus one |
| par_mode | input | 2 | 00/11 none, 01 odd, 10 even |
| two_stop | input | 1 | 1 = two stop bits |
| mp_mode | input | 2 | 00 off, 01 idle-line, 10 address-bit |
| own_addr | input | 8 | Address accepted in address-bit mode |
| m_valid | output | 1 | Buffered character available |
| m_ready | input | 1 | Consumer takes the character |
| m_data | output | 8 | Received character, zero-extended |
| m_addr | output | 1 | Character is an address / block start |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun |
| err_frame | output | 1 | Sticky framing error |
| err_break | output | 1 | Sticky break detect |
| err_any | output | 1 | OR of the four error flags |

## Verification
The hardest state to reach is break detection. The line must stay low through a whole frame, its stop bit and ten more bit times. The receiver must then be shown to resume cleanly once the line returns high. The stimulus drives a frame whose stop bit is replaced by twelve low bits, checks the break and framing flags, clears them and then sends an ordinary character. Overrun is also hard to produce: the consumer has to hold `m_ready` low across two complete frames. Address-bit filtering needs a mix of matching and non-matching addresses, so that both dropped and passed data frames can be told apart at the stream output.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_DATA, ST_ADDR, ST_PAR,
    ST_STOP1, ST_STOP2, ST_BREAK, ST_WAITHI
  } rx_state_t;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ODD  = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_OFF2 = 2'b11
  } par_mode_t;

  typedef enum logic [1:0] {
    MP_OFF  = 2'b00,
    MP_IDLE = 2'b01,
    MP_ABIT = 2'b10,
    MP_RSVD = 2'b11
  } mp_mode_t;

endpackage

// File: rtl/async_rx_baud.sv
module async_rx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= divisor);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr || tick)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/async_rx_vote.sv
module async_rx_vote #(
  parameter int OVS  = 8,
  parameter int PH_W = $clog2(OVS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [PH_W-1:0] phase,
  input  logic            line,
  output logic            mid,
  output logic            vote
);
  localparam int CENTER = OVS / 2;

  logic s_a, s_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_a <= 1'b1;
      s_b <= 1'b1;
    end else if (tick) begin
      if (phase == PH_W'(CENTER - 1)) s_a <= line;
      if (phase == PH_W'(CENTER))     s_b <= line;
    end
  end

  assign mid  = tick && (phase == PH_W'(CENTER + 1));
  assign vote = (s_a & s_b) | (s_a & line) | (s_b & line);
endmodule

// File: rtl/async_rx_frame.sv
module async_rx_frame
  import async_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OVS       = 8,
  parameter int IDLE_BITS = 10,
  parameter int BRK_BITS  = 10,
  parameter int LEN_W     = $clog2(DATA_W),
  parameter int PH_W      = $clog2(OVS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic              line,
  input  logic              mid,
  input  logic              vote,
  input  logic [LEN_W-1:0]  data_len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              abit_mode,
  input  logic              two_stop,
  output logic [PH_W-1:0]   phase,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              abit,
  output logic              mark,
  output logic              perr,
  output logic              ferr,
  output logic              brk
);
  localparam int IDLE_TICKS = IDLE_BITS * OVS;
  localparam int IC_W       = $clog2(IDLE_TICKS + 1);
  localparam int BC_W       = $clog2(BRK_BITS);

  rx_state_t         state;
  logic [LEN_W-1:0]  bitcnt;
  logic [DATA_W-1:0] shreg;
  logic              abit_r, pacc, pbit, mark_r;
  logic [IC_W-1:0]   idle_cnt;
  logic [BC_W-1:0]   brk_cnt;
  logic              bit_end;

  assign bit_end = tick && (phase == PH_W'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; phase <= '0; bitcnt <= '0; shreg <= '0;
      abit_r <= 1'b0; pacc <= 1'b0; pbit <= 1'b0; mark_r <= 1'b0;
      idle_cnt <= '0; brk_cnt <= '0;
    end else if (clr) begin
      state <= ST_IDLE; phase <= '0; bitcnt <= '0; shreg <= '0;
      abit_r <= 1'b0; pacc <= 1'b0; pbit <= 1'b0; mark_r <= 1'b0;
      idle_cnt <= '0; brk_cnt <= '0;
    end else begin
      if (tick) phase <= phase + 1'b1;
      if (done) mark_r <= 1'b0;
      if (state != ST_IDLE) idle_cnt <= '0;
      case (state)
        ST_IDLE: begin
          if (!line) idle_cnt <= '0;
          else if (tick && idle_cnt != IC_W'(IDLE_TICKS)) begin
            idle_cnt <= idle_cnt + 1'b1;
            if (idle_cnt == IC_W'(IDLE_TICKS - 1)) mark_r <= 1'b1;
          end
          if (tick && !line) begin
            state  <= ST_START;
            phase  <= PH_W'(1);
            shreg  <= '0;
            pacc   <= 1'b0;
            abit_r <= 1'b0;
            bitcnt <= '0;
          end
        end
        ST_START: begin
          if (mid && vote)  state <= ST_IDLE;
          else if (bit_end) state <= ST_DATA;
        end
        ST_DATA: begin
          if (mid) begin
            shreg[bitcnt] <= vote;
            pacc          <= pacc ^ vote;
          end
          if (bit_end) begin
            if (bitcnt == data_len)
              state <= abit_mode ? ST_ADDR : (par_en ? ST_PAR : ST_STOP1);
            else
              bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_ADDR: begin
          if (mid) begin
            abit_r <= vote;
            pacc   <= pacc ^ vote;
          end
          if (bit_end) state <= par_en ? ST_PAR : ST_STOP1;
        end
        ST_PAR: begin
          if (mid)     pbit  <= vote;
          if (bit_end) state <= ST_STOP1;
        end
        ST_STOP1: begin
          if (mid) begin
            if (vote) state <= two_stop ? ST_STOP2 : ST_IDLE;
            else begin
              state   <= ST_BREAK;
              brk_cnt <= '0;
            end
          end
        end
        ST_STOP2: if (mid) state <= ST_IDLE;
        ST_BREAK: begin
          if (mid) begin
            if (vote) state <= ST_IDLE;
            else if (brk_cnt == BC_W'(BRK_BITS - 1)) state <= ST_WAITHI;
            else brk_cnt <= brk_cnt + 1'b1;
          end
        end
        ST_WAITHI: if (line) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign done = (state == ST_STOP1) && mid;
  assign data = shreg;
  assign abit = abit_r;
  assign mark = mark_r;
  assign perr = par_en && (pacc ^ pbit ^ par_odd);
  assign ferr = !vote;
  assign brk  = (state == ST_BREAK) && mid && !vote &&
                (brk_cnt == BC_W'(BRK_BITS - 1));
endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int DATA_W    = 8,
  parameter int OVS       = 8,
  parameter int IDLE_BITS = 10,
  parameter int BRK_BITS  = 10,
  parameter int LEN_W     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              rxd,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [LEN_W-1:0]  data_len,
  input  logic [1:0]        par_mode,
  input  logic              two_stop,
  input  logic [1:0]        mp_mode,
  input  logic [DATA_W-1:0] own_addr,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_addr,
  output logic              err_parity,
  output logic              err_overrun,
  output logic              err_frame,
  output logic              err_break,
  output logic              err_any
);
  localparam int PH_W = $clog2(OVS);

  logic              sync1, line;
  logic              tick, mid, vote;
  logic [PH_W-1:0]   phase;
  logic              done, f_abit, f_mark, f_perr, f_ferr, f_brk;
  logic [DATA_W-1:0] f_data;
  logic              selected, load, is_addr;
  logic              par_en, par_odd, abit_mode;

  assign par_en    = (par_mode == PAR_ODD) || (par_mode == PAR_EVEN);
  assign par_odd   = (par_mode == PAR_ODD);
  assign abit_mode = (mp_mode == MP_ABIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      line  <= 1'b1;
    end else begin
      sync1 <= rxd;
      line  <= sync1;
    end
  end

  async_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .divisor(divisor), .tick(tick)
  );

  async_rx_vote #(.OVS(OVS), .PH_W(PH_W)) u_vote (
    .clk(clk), .rst_n(rst_n), .tick(tick), .phase(phase), .line(line),
    .mid(mid), .vote(vote)
  );

  async_rx_frame #(
    .DATA_W(DATA_W), .OVS(OVS), .IDLE_BITS(IDLE_BITS), .BRK_BITS(BRK_BITS),
    .LEN_W(LEN_W), .PH_W(PH_W)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .tick(tick), .line(line),
    .mid(mid), .vote(vote), .data_len(data_len), .par_en(par_en),
    .par_odd(par_odd), .abit_mode(abit_mode), .two_stop(two_stop),
    .phase(phase), .done(done), .data(f_data), .abit(f_abit), .mark(f_mark),
    .perr(f_perr), .ferr(f_ferr), .brk(f_brk)
  );

  always_comb begin
    case (mp_mode)
      MP_ABIT: is_addr = f_abit;
      MP_IDLE: is_addr = f_mark;
      default: is_addr = 1'b0;
    endcase
  end

  assign load = done && (!abit_mode || f_abit || selected);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0; m_data <= '0; m_addr <= 1'b0; selected <= 1'b0;
      err_parity <= 1'b0; err_overrun <= 1'b0;
      err_frame  <= 1'b0; err_break   <= 1'b0;
    end else if (soft_rst) begin
      m_valid <= 1'b0; selected <= 1'b0;
      err_parity <= 1'b0; err_overrun <= 1'b0;
      err_frame  <= 1'b0; err_break   <= 1'b0;
    end else begin
      if (done && abit_mode && f_abit) selected <= (f_data == own_addr);
      if (load) begin
        m_data  <= f_data;
        m_addr  <= is_addr;
        m_valid <= 1'b1;
        if (m_valid && !m_ready) err_overrun <= 1'b1;
      end else if (m_valid && m_ready) begin
        m_valid <= 1'b0;
      end
      if (done && f_perr) err_parity <= 1'b1;
      if (done && f_ferr) err_frame  <= 1'b1;
      if (f_brk)          err_break  <= 1'b1;
    end
  end

  assign err_any = err_parity | err_overrun | err_frame | err_break;
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              err_overrun,
  input logic              err_frame,
  input logic              err_break,
  input logic              err_any,
  input logic              load
);
  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!err_any && !m_valid)); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_any && !soft_rst) |=> err_any); // R7

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !soft_rst) |=> m_valid); // R3

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !load && !soft_rst) |=> $stable(m_data)); // R3

  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(m_valid)); // R4

  AST_BREAK_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_break) |-> err_frame); // R6
endmodule

bind async_rx async_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .err_overrun(err_overrun),
  .err_frame(err_frame), .err_break(err_break), .err_any(err_any),
  .load(load)
);

// File: tb/tb_async_rx.sv
module tb_async_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, soft_rst = 1'b0, rxd = 1'b1;
  logic [15:0] divisor = 16'd1;
  logic [2:0]  data_len = 3'd7;
  logic [1:0]  par_mode = 2'b00, mp_mode = 2'b00;
  logic        two_stop = 1'b0, m_ready = 1'b1;
  logic [7:0]  own_addr = 8'h5A;
  logic        m_valid, m_addr;
  logic [7:0]  m_data;
  logic        err_parity, err_overrun, err_frame, err_break, err_any;

  int n_chk = 0, n_bad = 0, n_out = 0;
  logic [8:0] exp_q[$];

  always #2.5 clk = ~clk;

  async_rx dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rxd(rxd),
    .divisor(divisor), .data_len(data_len), .par_mode(par_mode),
    .two_stop(two_stop), .mp_mode(mp_mode), .own_addr(own_addr),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_addr(m_addr),
    .err_parity(err_parity), .err_overrun(err_overrun), .err_frame(err_frame),
    .err_break(err_break), .err_any(err_any)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic push(input logic [7:0] d, input logic a);
    exp_q.push_back({a, d});
  endtask

  task automatic drive_bit(input logic v, input int bc);
    rxd = v;
    repeat (bc) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    repeat (n * (int'(divisor) + 1) * 8) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input logic has_a,
                            input logic a, input logic bad_p, input int stop_low);
    int   bc;
    logic p;
    bc = (int'(divisor) + 1) * 8;
    p  = 1'b0;
    drive_bit(1'b0, bc);
    for (int i = 0; i < nb; i++) begin
      drive_bit(d[i], bc);
      p ^= d[i];
    end
    if (has_a) begin
      drive_bit(a, bc);
      p ^= a;
    end
    if (par_mode == 2'b01) drive_bit(~p ^ bad_p, bc);
    if (par_mode == 2'b10) drive_bit(p ^ bad_p, bc);
    if (stop_low > 0) begin
      for (int i = 0; i < stop_low; i++) drive_bit(1'b0, bc);
      drive_bit(1'b1, bc);
    end else begin
      drive_bit(1'b1, bc);
      if (two_stop) drive_bit(1'b1, bc);
    end
    drive_bit(1'b1, bc);
  endtask

  task automatic pulse_soft();
    @(negedge clk) soft_rst = 1'b1;
    @(negedge clk) soft_rst = 1'b0;
  endtask

  // Monitor: pop expected items at each accepted handshake
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      logic [8:0] e;
      n_out++;
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R8: unexpected output actual %0h expected none", {m_addr, m_data});
      end else begin
        e = exp_q.pop_front();
        check({m_addr, m_data} == e, "R1 stream item", {m_addr, m_data}, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1: watchdog actual hung expected done");
    summary();
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    check(m_valid == 1'b0, "R11 valid", m_valid, 0);
    check(err_any == 1'b0, "R11 err_any", err_any, 0);
    rst_n = 1'b1;
    idle_bits(12);

    // R1: plain 8N1 frames
    push(8'hA5, 0); send_frame(8'hA5, 8, 0, 0, 0, 0);
    push(8'h3C, 0); send_frame(8'h3C, 8, 0, 0, 0, 0);
    check(exp_q.size() == 0, "R1 delivered", exp_q.size(), 0);

    // R2: short glitch must not start a frame
    base = n_out;
    @(negedge clk) rxd = 1'b0;
    repeat (2) @(negedge clk);
    rxd = 1'b1;
    idle_bits(4);
    check(n_out == base && !m_valid, "R2 glitch ignored", n_out - base, 0);
    check(err_frame == 1'b0, "R2 glitch no error", err_frame, 0);
    push(8'h81, 0); send_frame(8'h81, 8, 0, 0, 0, 0);

    // R1/R5: short lengths, even parity, two stops
    data_len = 3'd4; par_mode = 2'b10; two_stop = 1'b1;
    push(8'h15, 0); send_frame(8'h15, 5, 0, 0, 0, 0);
    data_len = 3'd0;
    push(8'h01, 0); send_frame(8'h01, 1, 0, 0, 0, 0);
    check(err_parity == 1'b0, "R5 good even parity", err_parity, 0);
    check(exp_q.size() == 0, "R1 short lengths", exp_q.size(), 0);

    // R5/R7: odd parity error, stickiness
    data_len = 3'd7; par_mode = 2'b01; two_stop = 1'b0;
    push(8'h6E, 0); send_frame(8'h6E, 8, 0, 0, 1, 0);
    check(err_parity == 1'b1, "R5 parity error", err_parity, 1);
    check(err_any == 1'b1, "R7 err_any", err_any, 1);
    push(8'h6F, 0); send_frame(8'h6F, 8, 0, 0, 0, 0);
    check(err_parity == 1'b1, "R7 sticky", err_parity, 1);
    pulse_soft();
    check(err_any == 1'b0, "R10 soft clear", err_any, 0);

    // R2: another divisor
    par_mode = 2'b00; divisor = 16'd4; pulse_soft();
    idle_bits(2);
    push(8'hC3, 0); send_frame(8'hC3, 8, 0, 0, 0, 0);
    check(exp_q.size() == 0, "R2 divisor 4", exp_q.size(), 0);
    divisor = 16'd1; pulse_soft(); idle_bits(2);

    // R3/R4: back-pressure and overrun
    m_ready = 1'b0;
    send_frame(8'h11, 8, 0, 0, 0, 0);
    idle_bits(2);
    check(m_valid == 1'b1 && m_data == 8'h11, "R3 held", m_data, 8'h11);
    check(err_overrun == 1'b0, "R4 no overrun yet", err_overrun, 0);
    send_frame(8'h22, 8, 0, 0, 0, 0);
    check(err_overrun == 1'b1, "R4 overrun", err_overrun, 1);
    check(m_data == 8'h22, "R4 overwrite", m_data, 8'h22);
    push(8'h22, 0);
    @(negedge clk) m_ready = 1'b1;
    repeat (4) @(negedge clk);
    check(m_valid == 1'b0 && exp_q.size() == 0, "R3 handshake", m_valid, 0);
    pulse_soft();

    // R6: framing error without break, then break
    push(8'h55, 0); send_frame(8'h55, 8, 0, 0, 0, 1);
    check(err_frame == 1'b1, "R6 framing", err_frame, 1);
    check(err_break == 1'b0, "R6 no break", err_break, 0);
    pulse_soft();
    push(8'h00, 0); send_frame(8'h00, 8, 0, 0, 0, 12);
    check(err_break == 1'b1, "R6 break", err_break, 1);
    check(err_frame == 1'b1, "R6 break framing", err_frame, 1);
    pulse_soft();
    idle_bits(2);
    push(8'h99, 0); send_frame(8'h99, 8, 0, 0, 0, 0);
    check(err_any == 1'b0 && exp_q.size() == 0, "R6 recovery", err_any, 0);

    // R8: address-bit mode
    mp_mode = 2'b10; pulse_soft();
    base = n_out;
    send_frame(8'h11, 8, 1, 0, 0, 0);
    push(8'h33, 1); send_frame(8'h33, 8, 1, 1, 0, 0);
    send_frame(8'h44, 8, 1, 0, 0, 0);
    push(8'h5A, 1); send_frame(8'h5A, 8, 1, 1, 0, 0);
    push(8'h77, 0); send_frame(8'h77, 8, 1, 0, 0, 0);
    check(n_out - base == 3, "R8 filtered count", n_out - base, 3);

    // R9: idle-line mode
    mp_mode = 2'b01;
    idle_bits(12);
    push(8'hA1, 1); send_frame(8'hA1, 8, 0, 0, 0, 0);
    push(8'hA2, 0); send_frame(8'hA2, 8, 0, 0, 0, 0);
    mp_mode = 2'b00;
    idle_bits(12);
    push(8'hB0, 0); send_frame(8'hB0, 8, 0, 0, 0, 0);
    check(exp_q.size() == 0, "R9 all delivered", exp_q.size(), 0);

    repeat (10) @(negedge clk);
    summary();
  end
endmodule